// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the producer and consumer positions of a circular queue held in memory whose depth is a power of two chosen at run time. Each position is a counter one bit wider than the index: the low `L` bits select the slot and bit `L` is a lap flag. The lap flag lets the block tell a full queue from an empty one without spending a slot. Here `L` is the `log2_size` input, from 0 to 19.

A producer or consumer strobe advances its pointer by one, modulo twice the depth. The block computes full and empty flags and the byte address of the slot each pointer selects. The address is a 32-byte aligned base plus the entry size times the index. The entry size is 16 bytes for command queues and 32 bytes for event queues.

The consumer value is a 32-bit word that also carries a 7-bit error code. Advancing the consumer never changes that code. A strobe that would overrun a full queue, or read from an empty one, is refused and flagged in the same cycle.

Top module: `ring_ptr_tracker`

## Requirements
- R1: After reset `prod_val` and `cons_val` are 0, `empty` is 1 and `full` is 0.
- R2: With `log2_size` = L, the index is bits [L-1:0] of a pointer and the lap flag is bit L. L = 0 gives a one-entry queue that is full after a single producer step.
- R3: `empty` is 1 exactly when the low L+1 bits of both pointers are equal. `full` is 1 exactly when the indices are equal and the lap flags differ.
- R4: An accepted producer step sets `prod_val` to (`prod_val`+1) with only the low L+1 bits kept; all higher bits become 0.
- R5: An accepted consumer step replaces only bits [L:0] of `cons_val` with the incremented value. Bits above L, including the error code in bits [30:24], keep their values.
- R6: A producer strobe while full is refused, with `ovf_err` high in that cycle. A consumer strobe while empty is refused, with `udf_err` high in that cycle.
- R7: The base address used for both slot addresses has bits [4:0] forced to 0 (bits 47:5 kept).
- R8: `prod_addr` = masked base + `entry_bytes` × producer index, and `cons_addr` = masked base + `entry_bytes` × consumer index.
- R9: `err_we` loads `err_code` into bits [30:24] of `cons_val` at the clock edge without changing the pointer bits. Bit 31 always reads 0.
- R10: Producer and consumer strobes in the same cycle are each judged against the state before the edge and act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 48 | Queue base byte address |
| log2_size | input | 5 | log2 of queue depth (0..19) |
| entry_bytes | input | 7 | Bytes per queue entry |
| prod_inc | input | 1 | Advance producer pointer |
| cons_inc | input | 1 | Advance consumer pointer |
| err_we | input | 1 | Load error code |
| err_code | input | 7 | Error code value |
| prod_val | output | 20 | Producer pointer (lap flag and index) |
| cons_val | output | 32 | Consumer word: error code in [30:24], pointer in [19:0] |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| ovf_err | output | 1 | Producer strobe refused (queue full) |
| udf_err | output | 1 | Consumer strobe refused (queue empty) |
| prod_addr | output | 48 | Byte address of producer slot |
| cons_addr | output | 48 | Byte address of consumer slot |

## Verification
A table drives a depth-4 queue through filling, refused overrun, draining, refused underrun and a producer lap. This separates a full queue from an empty one when the indices match, and shows whether a refused strobe really leaves the pointer unchanged. A depth change from 16 to 4 entries with both pointers at 20 shows that producer steps clear the bits above the lap flag while consumer steps keep them. A one-entry queue takes the full/empty logic to its boundary, including simultaneous strobes on a full queue. Address checks use an unaligned base with 16- and 32-byte entries, and error-code writes before and together with consumer steps show that the two fields stay apart.

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker #(
  parameter int ADDR_W   = 48,
  parameter int MAX_LOG2 = 19,
  parameter int SZ_W     = 5,
  parameter int ESZ_W    = 7,
  parameter int ERR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SZ_W-1:0]   log2_size,
  input  logic [ESZ_W-1:0]  entry_bytes,
  input  logic              prod_inc,
  input  logic              cons_inc,
  input  logic              err_we,
  input  logic [ERR_W-1:0]  err_code,
  output logic [MAX_LOG2:0] prod_val,
  output logic [31:0]       cons_val,
  output logic              full,
  output logic              empty,
  output logic              ovf_err,
  output logic              udf_err,
  output logic [ADDR_W-1:0] prod_addr,
  output logic [ADDR_W-1:0] cons_addr
);
  localparam int PTR_W   = MAX_LOG2 + 1;
  localparam int ERR_LSB = 24;
  localparam int GAP_W   = ERR_LSB - PTR_W;
  localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-5){1'b1}}, 5'b0};

  logic [SZ_W-1:0]  lg;
  logic [PTR_W-1:0] lap_bit, idx_mask, wi_mask, diff;
  logic [PTR_W-1:0] prod_q, cons_q, prod_nxt, cons_step, cons_nxt;
  logic [ERR_W-1:0] err_q;
  logic [ADDR_W-1:0] base_m;

  assign lg       = (log2_size > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : log2_size;
  assign lap_bit  = PTR_W'(1) << lg;
  assign idx_mask = lap_bit - PTR_W'(1);
  assign wi_mask  = lap_bit | idx_mask;

  assign diff  = (cons_q ^ prod_q) & wi_mask;
  assign full  = (diff == lap_bit);
  assign empty = (diff == '0);

  assign ovf_err = prod_inc & full;
  assign udf_err = cons_inc & empty;

  assign prod_nxt  = (prod_q + PTR_W'(1)) & wi_mask;
  assign cons_step = cons_q + PTR_W'(1);
  assign cons_nxt  = (cons_q & ~wi_mask) | (cons_step & wi_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
      err_q  <= '0;
    end else begin
      if (prod_inc && !full)  prod_q <= prod_nxt;
      if (cons_inc && !empty) cons_q <= cons_nxt;
      if (err_we)             err_q  <= err_code;
    end
  end

  assign base_m    = base_addr & BASE_MASK;
  assign prod_addr = base_m + ADDR_W'(entry_bytes) * ADDR_W'(prod_q & idx_mask);
  assign cons_addr = base_m + ADDR_W'(entry_bytes) * ADDR_W'(cons_q & idx_mask);

  assign prod_val = prod_q;
  assign cons_val = {1'b0, err_q, {GAP_W{1'b0}}, cons_q};
endmodule

// File: rtl/ring_ptr_tracker_chk.sv
module ring_ptr_tracker_chk #(
  parameter int PTR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prod_inc,
  input logic             cons_inc,
  input logic             err_we,
  input logic             full,
  input logic             empty,
  input logic [PTR_W-1:0] prod_val,
  input logic [31:0]      cons_val
);
  p_reset_empty_r1: assert property (@(posedge clk) $rose(rst_n) |-> empty && !full && prod_val == '0)
    else $error("p_reset_empty_r1");

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty))
    else $error("p_excl_r3");

  p_prod_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prod_inc && !full |=> prod_val != $past(prod_val))
    else $error("p_prod_moves_r4");

  p_prod_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_inc |=> $stable(prod_val))
    else $error("p_prod_idle_r4");

  p_err_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_we |=> $stable(cons_val[30:24]))
    else $error("p_err_kept_r5");

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prod_inc && full |=> $stable(prod_val))
    else $error("p_no_overflow_r6");

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cons_inc && empty |=> $stable(cons_val[PTR_W-1:0]))
    else $error("p_no_underflow_r6");

  p_bit31_zero_r9: assert property (@(posedge clk) disable iff (!rst_n) cons_val[31] == 1'b0)
    else $error("p_bit31_zero_r9");
endmodule

bind ring_ptr_tracker ring_ptr_tracker_chk #(.PTR_W(MAX_LOG2 + 1)) u_chk (.*);

// File: tb/tb_ring_ptr_tracker.sv
`timescale 1ns/1ps
module tb_ring_ptr_tracker;
  localparam int PER = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] base_addr = '0;
  logic [4:0]  log2_size = 5'd2;
  logic [6:0]  entry_bytes = 7'd16;
  logic        prod_inc = 1'b0, cons_inc = 1'b0, err_we = 1'b0;
  logic [6:0]  err_code = '0;
  logic [19:0] prod_val;
  logic [31:0] cons_val;
  logic        full, empty, ovf_err, udf_err;
  logic [47:0] prod_addr, cons_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #(PER/2) clk = ~clk;

  ring_ptr_tracker dut (.*);

  // {pinc, cinc, ovf, udf, prod[7:0], cons[7:0], full, empty}, depth 4
  localparam logic [21:0] VEC [15] = '{
    {1'b1,1'b0,1'b0,1'b0, 8'd1, 8'd0, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0, 8'd2, 8'd0, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0, 8'd3, 8'd0, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0, 8'd4, 8'd0, 1'b1,1'b0},
    {1'b1,1'b0,1'b1,1'b0, 8'd4, 8'd0, 1'b1,1'b0},
    {1'b0,1'b1,1'b0,1'b0, 8'd4, 8'd1, 1'b0,1'b0},
    {1'b1,1'b1,1'b0,1'b0, 8'd5, 8'd2, 1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0, 8'd5, 8'd3, 1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0, 8'd5, 8'd4, 1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0, 8'd5, 8'd5, 1'b0,1'b1},
    {1'b0,1'b1,1'b0,1'b1, 8'd5, 8'd5, 1'b0,1'b1},
    {1'b1,1'b0,1'b0,1'b0, 8'd6, 8'd5, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0, 8'd7, 8'd5, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0, 8'd0, 8'd5, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0, 8'd1, 8'd5, 1'b1,1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive strobes for one edge; check refusal flags before the edge
  task automatic step(input logic p, input logic c, input logic eo, input logic eu, input string req);
    @(negedge clk);
    prod_inc = p; cons_inc = c;
    #1;
    chk({req, " ovf_err"}, 64'(ovf_err), 64'(eo));
    chk({req, " udf_err"}, 64'(udf_err), 64'(eu));
    @(negedge clk);
    prod_inc = 1'b0; cons_inc = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #(PER * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] mb;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 prod_val", 64'(prod_val), 64'd0);
    chk("R1 cons_val", 64'(cons_val), 64'd0);
    chk("R1 empty", 64'(empty), 64'd1);
    chk("R1 full", 64'(full), 64'd0);

    // table, depth 4 (R3 flags, R4 producer, R5 consumer, R6 refusal, R10 both)
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18], "R6/R10 table");
      chk("R4 table prod", 64'(prod_val[7:0]), 64'(VEC[i][17:10]));
      chk("R5 table cons", 64'(cons_val[7:0]), 64'(VEC[i][9:2]));
      chk("R3 table full", 64'(full), 64'(VEC[i][1]));
      chk("R3 table empty", 64'(empty), 64'(VEC[i][0]));
    end

    // R7/R8 addresses: prod idx 1, cons idx 2 after one more consumer step
    step(1'b0, 1'b1, 1'b0, 1'b0, "R6 pre-addr");
    base_addr = 48'h1234_5678_9ABF;
    mb = 48'h1234_5678_9AA0;
    entry_bytes = 7'd16;
    #1;
    chk("R7/R8 prod_addr 16B", 64'(prod_addr), 64'(mb + 48'd16));
    chk("R7/R8 cons_addr 16B", 64'(cons_addr), 64'(mb + 48'd32));
    entry_bytes = 7'd32;
    #1;
    chk("R8 prod_addr 32B", 64'(prod_addr), 64'(mb + 48'd32));
    chk("R8 cons_addr 32B", 64'(cons_addr), 64'(mb + 48'd64));

    // R9 error code load, then R5 consumer step keeps it
    @(negedge clk); err_we = 1'b1; err_code = 7'h5A;
    @(negedge clk); err_we = 1'b0; #1;
    chk("R9 err load", 64'(cons_val), 64'h5A00_0006);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R5 err step");
    chk("R5 err kept", 64'(cons_val), 64'h5A00_0007);
    @(negedge clk); err_we = 1'b1; err_code = 7'h13; cons_inc = 1'b1;
    @(negedge clk); err_we = 1'b0; cons_inc = 1'b0; #1;
    chk("R9 err with step", 64'(cons_val), 64'h1300_0000);

    // R1 reset clears pointers and error code
    do_reset();
    chk("R1 reset cons_val", 64'(cons_val), 64'd0);
    chk("R1 reset prod_val", 64'(prod_val), 64'd0);
    chk("R1 reset empty", 64'(empty), 64'd1);

    // R4/R5 depth change 16 -> 4 with both pointers at 20
    log2_size = 5'd4;
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, "R6 fill16");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 drain16");
    end
    chk("R4 prod at 20", 64'(prod_val), 64'd20);
    log2_size = 5'd2;
    #1;
    chk("R3 empty after shrink", 64'(empty), 64'd1);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R6 shrink prod");
    chk("R4 high bits cleared", 64'(prod_val), 64'd5);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R6 shrink cons");
    chk("R5 high bits kept", 64'(cons_val), 64'd21);
    chk("R3 empty mixed", 64'(empty), 64'd1);

    // R2 one-entry queue, R10 both strobes while full
    do_reset();
    log2_size = 5'd0;
    base_addr = 48'h0000_0000_1000;
    entry_bytes = 7'd16;
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2 single");
    chk("R2 single prod", 64'(prod_val), 64'd1);
    chk("R2 single full", 64'(full), 64'd1);
    chk("R2 single empty", 64'(empty), 64'd0);
    chk("R2 single addr", 64'(prod_addr), 64'h1000);
    step(1'b1, 1'b0, 1'b1, 1'b0, "R6 single overrun");
    chk("R6 single prod held", 64'(prod_val), 64'd1);
    step(1'b1, 1'b1, 1'b1, 1'b0, "R10 both on full");
    chk("R10 prod blocked", 64'(prod_val), 64'd1);
    chk("R10 cons moved", 64'(cons_val), 64'd1);
    chk("R10 empty", 64'(empty), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule